// File: doc/BRIEF.md
# Adaptive Page-Close Policy Controller

This block decides, for each memory bank, whether the row just used should be closed right away or held open for a while in the hope of another hit. It runs one of two policies: an aggressive-close policy that asks for a close on every access, and a keep-open policy that holds a row open for a programmable number of cycles and asks for a close when that time runs out. Each further access to the bank while it is held open starts the hold again.

The choice of policy follows from how well earlier decisions worked. Each access event reports whether it hit the open row and whether the decision made earlier for that bank was to close or to hold. A hold that ended in a row miss counts as a mistake upward. A close that threw away a row that would have hit counts as a mistake downward. The two good outcomes leave the count alone. These counts are summed between update ticks and added to a 4-bit saturating mistake counter once per programmable interval. The controller moves to aggressive close only when the counter rises above a high threshold. It moves back to keep-open only when the counter falls below a low threshold. Between the two thresholds it keeps the current policy, which stops it flipping back and forth.

Top module: `page_close_ctrl`

## Requirements
- R1: In reset the mistake counter takes `cfg_start`, the policy is keep-open (`algo_close` = 0) and `close_req` is all zeros; the counter update interval restarts from zero.
- R2: An event with `ev_prior_close` = 0 (the earlier decision was to hold) and `ev_hit` = 0 (row miss) adds one to the mistake counter.
- R3: An event with `ev_prior_close` = 1 (the earlier decision was to close) and `ev_hit` = 1 (the row would have hit) subtracts one from the mistake counter.
- R4: Events with `ev_prior_close` = 1 and `ev_hit` = 0, or with `ev_prior_close` = 0 and `ev_hit` = 1, leave the mistake counter unchanged.
- R5: The policy changes to aggressive close only on an update where the new count is both greater than `cfg_hi_thr` and greater than the old count. In every other case the current policy is kept.
- R6: The policy changes to keep-open only on an update where the new count is both less than `cfg_lo_thr` and less than the old count.
- R7: The mistake counter saturates at 15 and at 0 and never wraps.
- R8: The counter and the policy change only on an update tick. A tick comes every `cfg_interval`+1 cycles, with the first one `cfg_interval` cycles after the first cycle out of reset. Events seen between ticks are summed as a signed net count, and that net count is applied at the next tick. With `cfg_interval` = 0, an event changes `algo_close` two cycles after it is presented.
- R9: Under aggressive close, an access to bank b sets bit b of `close_req` for exactly one cycle, in the cycle after the access.
- R10: Under keep-open, an access to bank b loads that bank's hold time with `cfg_timeout`. Bit b of `close_req` pulses for one cycle `cfg_timeout`+1 cycles after the most recent access to that bank, and a later access restarts the count. A `cfg_timeout` of 0 gives the same response as R9.
- R11: While `enable` is low, `algo_close` reads 1 and accesses close at once as in R9. Any bank still being held gets a close request in the next cycle, and its hold is cancelled so that it gives no later expiry request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Adaptive policy enable; low forces aggressive close |
| cfg_start | input | 4 | Mistake counter value loaded in reset |
| cfg_hi_thr | input | 4 | Threshold the count must rise above to select aggressive close |
| cfg_lo_thr | input | 4 | Threshold the count must fall below to select keep-open |
| cfg_interval | input | 8 | Cycles between counter updates, minus one |
| cfg_timeout | input | 8 | Keep-open hold time in cycles |
| ev_valid | input | 1 | An access event is presented this cycle |
| ev_bank | input | 2 | Bank of the access |
| ev_hit | input | 1 | 1 = row hit (or would have hit), 0 = row miss |
| ev_prior_close | input | 1 | 1 = earlier decision for this bank was close, 0 = hold |
| close_req | output | 4 | Per-bank close request, bit b for bank b, one-cycle pulses |
| algo_close | output | 1 | 1 = aggressive close in force, 0 = keep-open |

## Verification
The assertions on the hysteresis and the saturation assume that the thresholds and the interval stay fixed while out of reset, and that `cfg_hi_thr` is not below `cfg_lo_thr`. The stimulus changes configuration only while reset is held and always uses thresholds in that order. The timer assertions assume at most one access event per cycle, which the single event port already guarantees. Both the hold-time checks and the cancel-on-disable checks rely on `cfg_timeout` staying fixed while a hold runs. The bench changes it only across a reset.

// File: rtl/pcc_pkg.sv
// Shared types and helpers for the adaptive page-close controller.
// Assumes: one access event per cycle at most.
package pcc_pkg;

    typedef enum logic {
        ALG_KEEP  = 1'b0,
        ALG_CLOSE = 1'b1
    } algo_e;

    // Map an access outcome to its effect on the mistake count.
    function automatic logic signed [1:0] outcome_delta(input logic hit, input logic prior_close);
        if (!prior_close && !hit)
            return 2'sb01;   // held open, then missed
        else if (prior_close && hit)
            return 2'sb11;   // closed, then the row would have hit
        else
            return 2'sb00;   // decision was right
    endfunction

endpackage

// File: rtl/pcc_interval.sv
// Update-interval tick generator.
// Raises tick for one cycle every cfg_interval+1 cycles, starting its count at reset.
// Assumes: cfg_interval is held steady while out of reset.
module pcc_interval #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] cfg_interval,
    output logic              tick
);

    logic [RATE_W-1:0] tcnt_q;

    assign tick = (tcnt_q == cfg_interval);

    // Count cycles up to the interval, then restart.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tcnt_q <= '0;
        else if (tick)
            tcnt_q <= '0;
        else
            tcnt_q <= tcnt_q + 1'b1;
    end

    // R8: a nonzero interval never yields back-to-back ticks
    p_tick_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cfg_interval != '0) |=> !tick);

endmodule

// File: rtl/pcc_mistake_tracker.sv
// Mistake counter with net-event accumulator and hysteretic policy select.
// Events are summed into a saturating signed accumulator. On each tick the sum
// is added to a saturating counter, and the policy is reconsidered from the
// old and new counts.
// Assumes: cfg_hi_thr >= cfg_lo_thr, and the thresholds are steady out of reset.
module pcc_mistake_tracker
    import pcc_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int ACC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ev_valid,
    input  logic             ev_hit,
    input  logic             ev_prior_close,
    input  logic [CNT_W-1:0] cfg_start,
    input  logic [CNT_W-1:0] cfg_hi_thr,
    input  logic [CNT_W-1:0] cfg_lo_thr,
    output algo_e            algo_q
);

    localparam int SUM_W = ((ACC_W > CNT_W) ? ACC_W : CNT_W) + 2;
    localparam logic [CNT_W-1:0]        CNT_MAX = {CNT_W{1'b1}};
    localparam logic signed [SUM_W-1:0] SUM_MAX = SUM_W'(2**CNT_W - 1);
    localparam logic signed [ACC_W:0]   ACC_HI  = (ACC_W+1)'(2**(ACC_W-1) - 1);
    localparam logic signed [ACC_W:0]   ACC_LO  = (ACC_W+1)'(-(2**(ACC_W-1)));

    logic signed [1:0]       delta;
    logic signed [ACC_W-1:0] acc_q, acc_sat, acc_d;
    logic signed [ACC_W:0]   acc_ext;
    logic signed [SUM_W-1:0] sum;
    logic [CNT_W-1:0]        cnt_q, cnt_d;
    algo_e                   algo_d;

    assign delta = ev_valid ? outcome_delta(ev_hit, ev_prior_close) : 2'sb00;

    // Add this cycle's outcome to the accumulator, clamped to its range.
    always_comb begin
        acc_ext = {acc_q[ACC_W-1], acc_q} + {{(ACC_W-1){delta[1]}}, delta};
        if (acc_ext > ACC_HI)
            acc_sat = ACC_HI[ACC_W-1:0];
        else if (acc_ext < ACC_LO)
            acc_sat = ACC_LO[ACC_W-1:0];
        else
            acc_sat = acc_ext[ACC_W-1:0];
        acc_d = tick ? {{(ACC_W-2){delta[1]}}, delta} : acc_sat;
    end

    // Apply the accumulated net count to the counter, saturating at both ends.
    always_comb begin
        sum = {{(SUM_W-CNT_W){1'b0}}, cnt_q} + {{(SUM_W-ACC_W){acc_q[ACC_W-1]}}, acc_q};
        if (sum[SUM_W-1])
            cnt_d = '0;
        else if (sum > SUM_MAX)
            cnt_d = CNT_MAX;
        else
            cnt_d = sum[CNT_W-1:0];
    end

    // Pick the next policy from the direction and level of the new count.
    always_comb begin
        algo_d = algo_q;
        if (cnt_d > cfg_hi_thr && cnt_d > cnt_q)
            algo_d = ALG_CLOSE;
        else if (cnt_d < cfg_lo_thr && cnt_d < cnt_q)
            algo_d = ALG_KEEP;
    end

    // Hold accumulator, counter and policy; counter and policy move only on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            cnt_q  <= cfg_start;
            algo_q <= ALG_KEEP;
        end else begin
            acc_q <= acc_d;
            if (tick) begin
                cnt_q  <= cnt_d;
                algo_q <= algo_d;
            end
        end
    end

    // R8: the counter is frozen between ticks
    p_hold_between_ticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));

    // R7: a full counter never wraps on a non-negative update
    p_sat_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !acc_q[ACC_W-1] && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

    // R7: an empty counter never wraps on a non-positive update
    p_sat_bottom_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (acc_q[ACC_W-1] || acc_q == '0) && cnt_q == '0) |=> cnt_q == '0);

    // R5: entry to aggressive close needs a rising count above the high threshold
    p_rise_to_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(algo_q) |-> (cnt_q > $past(cnt_q) && cnt_q > $past(cfg_hi_thr)));

    // R6: entry to keep-open needs a falling count below the low threshold
    p_fall_to_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(algo_q) |-> (cnt_q < $past(cnt_q) && cnt_q < $past(cfg_lo_thr)));

endmodule

// File: rtl/pcc_bank_timer.sv
// Per-bank keep-open hold timer and close-request generator.
// Under close policy an access asks for a close next cycle. Under keep-open it
// (re)loads the hold time, and expiry raises a one-cycle request.
// Assumes: close_mode is high whenever enable is low.
module pcc_bank_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             close_mode,
    input  logic             access,
    input  logic [TMO_W-1:0] cfg_timeout,
    output logic             req_q
);

    logic [TMO_W-1:0] tmr_q;

    // Run the hold count and form the registered close request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
            req_q <= 1'b0;
        end else if (!enable) begin
            tmr_q <= '0;
            req_q <= access || (tmr_q != '0);
        end else if (access) begin
            if (close_mode) begin
                tmr_q <= '0;
                req_q <= 1'b1;
            end else begin
                tmr_q <= cfg_timeout;
                req_q <= (cfg_timeout == '0);
            end
        end else if (tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
            req_q <= (tmr_q == TMO_W'(1));
        end else begin
            req_q <= 1'b0;
        end
    end

    // R9: an access under close policy requests at once and holds nothing
    p_close_now_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && access && close_mode) |=> (req_q && tmr_q == '0));

    // R10: an access under keep-open loads the programmed hold time
    p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && access && !close_mode) |=> tmr_q == $past(cfg_timeout));

    // R10: the last hold cycle ends in a close request
    p_expire_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !access && tmr_q == TMO_W'(1)) |=> req_q);

    // R11: disabling cancels any running hold
    p_disable_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> tmr_q == '0);

endmodule

// File: rtl/page_close_ctrl.sv
// Adaptive page-close policy controller, top level.
// Ties the update-interval tick, the mistake tracker and one hold timer per bank.
// Assumes: at most one access event per cycle; configuration changes only in reset.
module page_close_ctrl
    import pcc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int CNT_W     = 4,
    parameter int ACC_W     = 6,
    parameter int RATE_W    = 8,
    parameter int TMO_W     = 8,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [CNT_W-1:0]     cfg_start,
    input  logic [CNT_W-1:0]     cfg_hi_thr,
    input  logic [CNT_W-1:0]     cfg_lo_thr,
    input  logic [RATE_W-1:0]    cfg_interval,
    input  logic [TMO_W-1:0]     cfg_timeout,
    input  logic                 ev_valid,
    input  logic [BANK_W-1:0]    ev_bank,
    input  logic                 ev_hit,
    input  logic                 ev_prior_close,
    output logic [NUM_BANKS-1:0] close_req,
    output logic                 algo_close
);

    logic  tick;
    algo_e algo_q;

    pcc_interval #(.RATE_W(RATE_W)) u_interval (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_interval (cfg_interval),
        .tick         (tick)
    );

    pcc_mistake_tracker #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_tracker (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick           (tick),
        .ev_valid       (ev_valid),
        .ev_hit         (ev_hit),
        .ev_prior_close (ev_prior_close),
        .cfg_start      (cfg_start),
        .cfg_hi_thr     (cfg_hi_thr),
        .cfg_lo_thr     (cfg_lo_thr),
        .algo_q         (algo_q)
    );

    // Disabled operation always presents the aggressive-close policy.
    assign algo_close = !enable || (algo_q == ALG_CLOSE);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pcc_bank_timer #(.TMO_W(TMO_W)) u_timer (
            .clk         (clk),
            .rst_n       (rst_n),
            .enable      (enable),
            .close_mode  (algo_close),
            .access      (ev_valid && ev_bank == BANK_W'(b)),
            .cfg_timeout (cfg_timeout),
            .req_q       (close_req[b])
        );
    end

endmodule

// File: tb/page_close_ctrl_test.sv
// Scoreboard bench: tests push expected outputs tagged by cycle, and a monitor
// compares them at the falling edge of that cycle.
module page_close_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1;
    logic [3:0] cfg_start = 4'd8, cfg_hi_thr = 4'd10, cfg_lo_thr = 4'd5;
    logic [7:0] cfg_interval = 8'd0, cfg_timeout = 8'd250;
    logic       ev_valid = 1'b0;
    logic [1:0] ev_bank = 2'd0;
    logic       ev_hit = 1'b0, ev_prior_close = 1'b0;
    logic [3:0] close_req;
    logic       algo_close;

    page_close_ctrl uut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_start(cfg_start), .cfg_hi_thr(cfg_hi_thr), .cfg_lo_thr(cfg_lo_thr),
        .cfg_interval(cfg_interval), .cfg_timeout(cfg_timeout),
        .ev_valid(ev_valid), .ev_bank(ev_bank), .ev_hit(ev_hit),
        .ev_prior_close(ev_prior_close),
        .close_req(close_req), .algo_close(algo_close)
    );

    always #2 clk = ~clk;   // 250 MHz

    typedef struct {
        int         cyc;
        logic [3:0] req;
        logic       algo;
        bit         on_req;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   n_run = 0, n_fail = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every expectation due in this cycle.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == cyc) begin
                n_run++;
                if (sb[i].on_req && close_req !== sb[i].req) begin
                    n_fail++;
                    $display("FAIL %s cyc %0d: close_req=%b expected %b", sb[i].tag, cyc, close_req, sb[i].req);
                end else if (!sb[i].on_req && algo_close !== sb[i].algo) begin
                    n_fail++;
                    $display("FAIL %s cyc %0d: algo_close=%b expected %b", sb[i].tag, cyc, algo_close, sb[i].algo);
                end
                sb.delete(i);
            end else if (sb[i].cyc < cyc) begin
                n_run++;
                n_fail++;
                $display("FAIL %s: check for cyc %0d missed, actual none expected sample", sb[i].tag, sb[i].cyc);
                sb.delete(i);
            end
        end
    end

    task automatic exp_req(input int c, input logic [3:0] v, input string t);
        exp_t e;
        e.cyc = c; e.req = v; e.algo = 1'b0; e.on_req = 1'b1; e.tag = t;
        sb.push_back(e);
    endtask

    task automatic exp_alg(input int c, input logic v, input string t);
        exp_t e;
        e.cyc = c; e.req = '0; e.algo = v; e.on_req = 1'b0; e.tag = t;
        sb.push_back(e);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step();
    endtask

    task automatic send(input int b, input logic hit, input logic pc);
        ev_valid = 1'b1; ev_bank = b[1:0]; ev_hit = hit; ev_prior_close = pc;
        step();
        ev_valid = 1'b0;
    endtask

    task automatic inc(input int b);  send(b, 1'b0, 1'b0); endtask   // hold then miss
    task automatic dec(input int b);  send(b, 1'b1, 1'b1); endtask   // close then would-hit
    task automatic good_keep(input int b);  send(b, 1'b1, 1'b0); endtask
    task automatic good_close(input int b); send(b, 1'b0, 1'b1); endtask

    task automatic do_reset(input logic [3:0] st, input logic [3:0] hi, input logic [3:0] lo,
                            input logic [7:0] iv, input logic [7:0] to);
        rst_n = 1'b0; enable = 1'b1;
        cfg_start = st; cfg_hi_thr = hi; cfg_lo_thr = lo; cfg_interval = iv; cfg_timeout = to;
        idle(3);
        rst_n = 1'b1;
        exp_req(cyc, 4'b0000, "R1 reset requests");
        exp_alg(cyc, 1'b0, "R1 reset policy");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    initial begin : tests
        int n, m, p, q, s;

        // R2, R5: rise through the band, switch only above the high threshold
        do_reset(4'd8, 4'd10, 4'd5, 8'd0, 8'd250);
        n = cyc;
        exp_alg(n + 3, 1'b0, "R5 count 10 not above high");
        exp_alg(n + 4, 1'b1, "R2 R5 count 11 selects close");
        for (int i = 0; i < 3; i++) inc(0);
        idle(2);
        // R9: close policy requests the accessed bank for one cycle
        m = cyc;
        exp_req(m + 1, 4'b0100, "R9 immediate close bank2");
        exp_req(m + 2, 4'b0000, "R9 single-cycle pulse");
        good_keep(2);
        idle(1);
        // R3, R4, R6: fall back through the band
        p = cyc;
        exp_alg(p + 7, 1'b1, "R6 count 5 not below low");
        exp_alg(p + 11, 1'b1, "R4 neutral outcomes leave count");
        exp_alg(p + 12, 1'b0, "R3 R6 count 4 selects keep");
        for (int i = 0; i < 6; i++) dec(3);
        good_close(3); good_keep(3); good_close(3); good_keep(3);
        dec(3);
        idle(3);

        // R7: saturation at the top
        do_reset(4'd14, 4'd13, 4'd13, 8'd0, 8'd250);
        p = cyc;
        exp_alg(p + 2, 1'b1, "R7 count 15 selects close");
        exp_alg(p + 7, 1'b1, "R7 no wrap above 15");
        exp_alg(p + 9, 1'b1, "R7 two steps down from 15");
        exp_alg(p + 10, 1'b0, "R7 three steps down from 15");
        for (int i = 0; i < 6; i++) inc(1);
        for (int i = 0; i < 3; i++) dec(1);
        idle(3);

        // R7: saturation at the bottom
        do_reset(4'd1, 4'd4, 4'd3, 8'd0, 8'd250);
        p = cyc;
        exp_alg(p + 5, 1'b0, "R7 floor keeps keep-open");
        exp_alg(p + 9, 1'b0, "R7 four steps up from 0");
        exp_alg(p + 10, 1'b1, "R7 five steps up from 0");
        for (int i = 0; i < 4; i++) dec(0);
        for (int i = 0; i < 5; i++) inc(0);
        idle(3);

        // R10: keep-open hold time, restart and two banks
        do_reset(4'd8, 4'd10, 4'd5, 8'd0, 8'd5);
        n = cyc;
        exp_req(n + 5, 4'b0000, "R10 not yet expired");
        exp_req(n + 6, 4'b0010, "R10 expiry bank1");
        exp_req(n + 7, 4'b0000, "R10 expiry pulse ends");
        good_keep(1);
        idle(7);
        q = cyc;
        exp_req(q + 6, 4'b0000, "R10 restart delays expiry");
        exp_req(q + 9, 4'b0010, "R10 expiry after restart");
        good_keep(1);
        idle(2);
        good_keep(1);
        idle(8);
        s = cyc;
        exp_req(s + 6, 4'b0001, "R10 bank0 expiry");
        exp_req(s + 7, 4'b1000, "R10 bank3 expiry");
        good_keep(0);
        good_keep(3);
        idle(8);

        // R10: zero hold time behaves as immediate close
        do_reset(4'd8, 4'd10, 4'd5, 8'd0, 8'd0);
        n = cyc;
        exp_req(n + 1, 4'b0100, "R10 zero timeout closes");
        exp_req(n + 2, 4'b0000, "R10 zero timeout pulse ends");
        good_keep(2);
        idle(3);

        // R11: enable low forces close and cancels a running hold
        do_reset(4'd8, 4'd10, 4'd5, 8'd0, 8'd20);
        n = cyc;
        good_keep(1);
        idle(2);
        m = cyc;
        exp_alg(m, 1'b1, "R11 disabled shows close");
        exp_req(m + 1, 4'b0010, "R11 held bank closed");
        exp_req(m + 2, 4'b0000, "R11 cancel pulse ends");
        exp_req(n + 21, 4'b0000, "R11 no late expiry");
        enable = 1'b0;
        idle(2);
        exp_req(m + 3, 4'b1000, "R11 access while disabled");
        good_keep(3);
        idle(17);
        enable = 1'b1;
        exp_alg(cyc, 1'b0, "R11 re-enable restores keep");
        idle(2);

        // R8: net events applied only at the interval tick
        do_reset(4'd8, 4'd9, 4'd5, 8'd7, 8'd250);
        n = cyc;
        exp_alg(n + 7, 1'b0, "R8 no update before tick");
        exp_alg(n + 8, 1'b1, "R8 net +2 applied at tick");
        for (int i = 0; i < 3; i++) inc(0);
        dec(0);
        idle(6);

        while (sb.size() != 0) step();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule